// File: doc/BRIEF.md
# UART Interrupt Identification and Modem Status Logic

This block merges the event sources of a serial port into one interrupt request line and a prioritized identification byte for the host. Four category enables gate the sources. Ranked from highest to lowest, the sources are receive line errors, received data (trigger level reached or stale-data timeout), transmit holding empty, and modem status change. The host reads the identification byte to find the most urgent cause, then services that source.

The block also keeps the modem status value. The value holds four line states and four change flags, and the change flags clear when the host reads the value. In loopback mode the four modem control outputs are routed back internally in place of the external modem lines. The shift engines, the word storage and the baud divisor sit outside this block. The block receives only their status: the receive level, line-error and timeout indications, and the holding-empty level.

Top module: `uart_irq_ident`

## Requirements
- R1: `en_view` shows `int_en` in bits 3:0 and reads 0 in bits 7:4. Enable bit 0 covers received data, bit 1 transmit empty, bit 2 line status and bit 3 modem status.
- R2: When `line_err` is high and `int_en[2]` is set, `id_val[3:0]` is 4'h6 (code 011). This holds whatever other sources are pending.
- R3: With `int_en[0]` set, received data is pending when `rx_level` reaches the threshold, and `id_val[3:0]` is then 4'h4 (code 010). The threshold is 1 when `fifo_en` is 0. When `fifo_en` is 1, `trig_sel` picks it: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14.
- R4: With `int_en[0]` set, `rx_timeout` high and the threshold not reached, `id_val[3:0]` is 4'hC (code 110). This code is below line status and above transmit empty.
- R5: A transmit-empty event is latched one clock after `thr_empty` rises, or one clock after `int_en[1]` rises while `thr_empty` is high. While latched and enabled it gives `id_val[3:0]` 4'h2 (code 001). The event clears at the clock edge where `thr_write` is high. It also clears at an edge where `id_read` is high while the byte reports this code.
- R6: When any modem change flag is set and `int_en[3]` is set, `id_val[3:0]` is 4'h0 (code 000). This is the lowest priority.
- R7: `id_val[0]` is 1 exactly when nothing enabled is pending. `id_val[7:6]` is 11 when `fifo_en` is 1 and 00 otherwise. `id_val[5:4]` is 0.
- R8: `msr_val` = {dcd, ri, dsr, cts, d_dcd, ri_end, d_dsr, d_cts}, where the line states are active-high. It updates one clock after the line changes. A line's flag sets when its state differs from the previous clock's state. `ri_end` sets only when the ring state goes from asserted to deasserted, that is, when the active-low pin goes low to high.
- R9: A clock edge with `msr_read` high clears all four change flags. A change seen at that same edge still sets its flag.
- R10: With `loopback` high, `mctl` bits {3,2,1,0} drive dcd, ri, dsr and cts respectively, and `modem_n` has no effect on `msr_val`.
- R11: `irq` equals `mctl[3]` AND (any enabled source pending).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| int_en | input | 4 | Category enables |
| fifo_en | input | 1 | Word storage enabled |
| trig_sel | input | 2 | Receive trigger select |
| rx_level | input | LVL_W | Words held in receive storage |
| rx_timeout | input | 1 | Stale receive data indication |
| line_err | input | 1 | Receive line error pending (overrun, parity, framing, break) |
| thr_empty | input | 1 | Transmit holding register empty |
| thr_write | input | 1 | Host writes the holding register |
| id_read | input | 1 | Host reads the identification byte |
| msr_read | input | 1 | Host reads the modem status value |
| loopback | input | 1 | Loopback mode |
| mctl | input | 4 | Modem controls {out2, out1, dtr, rts} |
| modem_n | input | 4 | Active-low modem lines {dcd, ri, dsr, cts} |
| irq | output | 1 | Interrupt request |
| id_val | output | 8 | Identification byte |
| en_view | output | 8 | Enable readback |
| msr_val | output | 8 | Modem status and change flags |

## Verification
The bench builds the block with its default parameters: a 5-bit receive level and trigger levels of 1, 4, 8 and 14. With these values it drives each trigger setting one word below and exactly at its threshold, including the 14-word setting. The same build also reaches the one-word threshold used with storage disabled. Priority is checked by peeling sources away one at a time from a state where all four are pending. In loopback, control values are chosen so that one edge produces a ring assertion and a later edge produces the trailing ring transition. Those values show that only the trailing transition sets a flag and that the external pins are ignored.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    typedef enum logic [2:0] {
        ID_MODEM   = 3'b000,
        ID_TXEMPTY = 3'b001,
        ID_RXDATA  = 3'b010,
        ID_LINE    = 3'b011,
        ID_TIMEOUT = 3'b110
    } irq_code_e;

    // index of each line inside the 4-bit modem vectors
    localparam int MS_CTS = 0;
    localparam int MS_DSR = 1;
    localparam int MS_RI  = 2;
    localparam int MS_DCD = 3;

    typedef struct packed {
        logic [3:0] stat;
        logic [3:0] delta;
    } modem_st_t;

    typedef struct packed {
        logic empty;
        logic en;
        logic pend;
    } thre_st_t;

endpackage

// File: rtl/uart_irq_modem.sv
module uart_irq_modem
    import uart_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       loopback,
    input  logic [3:0] mctl,
    input  logic [3:0] modem_n,
    input  logic       msr_read,
    output logic [3:0] stat,
    output logic [3:0] delta
);

    modem_st_t st_d, st_q;
    logic [3:0] line_now;
    logic [3:0] chg;

    always_comb begin
        line_now     = loopback ? mctl : ~modem_n;
        chg          = line_now ^ st_q.stat;
        // ring flag only on the trailing edge (asserted -> deasserted)
        chg[MS_RI]   = st_q.stat[MS_RI] & ~line_now[MS_RI];
        st_d.stat    = line_now;
        st_d.delta   = (msr_read ? 4'b0000 : st_q.delta) | chg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat  = st_q.stat;
    assign delta = st_q.delta;

    // R8
    ring_trailing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.delta[MS_RI]) |-> ($past(st_q.stat[MS_RI]) && !st_q.stat[MS_RI]));

    // R9
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msr_read |=> ((st_q.delta == 4'b0000) || (st_q.stat != $past(st_q.stat))));

endmodule

// File: rtl/uart_irq_thre.sv
module uart_irq_thre
    import uart_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic thr_empty,
    input  logic en_tx,
    input  logic thr_write,
    input  logic id_ack,
    output logic pend
);

    thre_st_t st_d, st_q;
    logic set_ev;

    always_comb begin
        set_ev     = (thr_empty & ~st_q.empty) | (en_tx & ~st_q.en & thr_empty);
        st_d.empty = thr_empty;
        st_d.en    = en_tx;
        st_d.pend  = (st_q.pend | set_ev) & ~thr_write & ~id_ack;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.empty <= 1'b1;
            st_q.en    <= 1'b0;
            st_q.pend  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend = st_q.pend;

    // R5
    write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        thr_write |=> !pend);

    // R5
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        id_ack |=> !pend);

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
#(
    parameter int LVL_W   = 5,
    parameter int TRIG_L0 = 1,
    parameter int TRIG_L1 = 4,
    parameter int TRIG_L2 = 8,
    parameter int TRIG_L3 = 14
) (
    input  logic [3:0]       en,
    input  logic             line_err,
    input  logic             fifo_en,
    input  logic [1:0]       trig_sel,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             rx_timeout,
    input  logic             tx_pend,
    input  logic             modem_chg,
    output logic             pending,
    output irq_code_e        code
);

    localparam logic [LVL_W-1:0] TRIG_TAB [4] = '{LVL_W'(TRIG_L0), LVL_W'(TRIG_L1),
                                                  LVL_W'(TRIG_L2), LVL_W'(TRIG_L3)};
    localparam logic [LVL_W-1:0] ONE_WORD = LVL_W'(1);

    logic [LVL_W-1:0] thresh;
    logic rx_avail;
    logic p_line, p_rx, p_to, p_tx, p_ms;

    always_comb begin
        thresh   = fifo_en ? TRIG_TAB[trig_sel] : ONE_WORD;
        rx_avail = (rx_level >= thresh);
        p_line   = en[2] & line_err;
        p_rx     = en[0] & rx_avail;
        p_to     = en[0] & rx_timeout;
        p_tx     = en[1] & tx_pend;
        p_ms     = en[3] & modem_chg;
        pending  = p_line | p_rx | p_to | p_tx | p_ms;
        if (p_line)     code = ID_LINE;
        else if (p_rx)  code = ID_RXDATA;
        else if (p_to)  code = ID_TIMEOUT;
        else if (p_tx)  code = ID_TXEMPTY;
        else            code = ID_MODEM;
    end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int LVL_W   = 5,
    parameter int TRIG_L0 = 1,
    parameter int TRIG_L1 = 4,
    parameter int TRIG_L2 = 8,
    parameter int TRIG_L3 = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       int_en,
    input  logic             fifo_en,
    input  logic [1:0]       trig_sel,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             rx_timeout,
    input  logic             line_err,
    input  logic             thr_empty,
    input  logic             thr_write,
    input  logic             id_read,
    input  logic             msr_read,
    input  logic             loopback,
    input  logic [3:0]       mctl,
    input  logic [3:0]       modem_n,
    output logic             irq,
    output logic [7:0]       id_val,
    output logic [7:0]       en_view,
    output logic [7:0]       msr_val
);

    logic [3:0] ms_stat, ms_delta;
    logic       tx_pend, pending, id_ack;
    irq_code_e  code;

    uart_irq_modem u_modem (
        .clk      (clk),
        .rst_n    (rst_n),
        .loopback (loopback),
        .mctl     (mctl),
        .modem_n  (modem_n),
        .msr_read (msr_read),
        .stat     (ms_stat),
        .delta    (ms_delta)
    );

    uart_irq_thre u_thre (
        .clk       (clk),
        .rst_n     (rst_n),
        .thr_empty (thr_empty),
        .en_tx     (int_en[1]),
        .thr_write (thr_write),
        .id_ack    (id_ack),
        .pend      (tx_pend)
    );

    uart_irq_prio #(
        .LVL_W   (LVL_W),
        .TRIG_L0 (TRIG_L0),
        .TRIG_L1 (TRIG_L1),
        .TRIG_L2 (TRIG_L2),
        .TRIG_L3 (TRIG_L3)
    ) u_prio (
        .en         (int_en),
        .line_err   (line_err),
        .fifo_en    (fifo_en),
        .trig_sel   (trig_sel),
        .rx_level   (rx_level),
        .rx_timeout (rx_timeout),
        .tx_pend    (tx_pend),
        .modem_chg  (|ms_delta),
        .pending    (pending),
        .code       (code)
    );

    always_comb begin
        id_ack  = id_read & pending & (code == ID_TXEMPTY);
        irq     = mctl[3] & pending;
        id_val  = {{2{fifo_en}}, 2'b00, code, ~pending};
        en_view = {4'b0000, int_en};
        msr_val = {ms_stat, ms_delta};
    end

    // R2
    line_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_en[2] && line_err) |-> (id_val[3:0] == 4'h6));

    // R7
    irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !id_val[0]);

    // R11
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mctl[3] |-> !irq);

endmodule

// File: tb/uart_irq_ident_tb_top.sv
module uart_irq_ident_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] int_en;
    logic       fifo_en;
    logic [1:0] trig_sel;
    logic [4:0] rx_level;
    logic       rx_timeout, line_err, thr_empty, thr_write, id_read, msr_read, loopback;
    logic [3:0] mctl, modem_n;
    logic       irq;
    logic [7:0] id_val, en_view, msr_val;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    uart_irq_ident dut_i (
        .clk(clk), .rst_n(rst_n), .int_en(int_en), .fifo_en(fifo_en),
        .trig_sel(trig_sel), .rx_level(rx_level), .rx_timeout(rx_timeout),
        .line_err(line_err), .thr_empty(thr_empty), .thr_write(thr_write),
        .id_read(id_read), .msr_read(msr_read), .loopback(loopback),
        .mctl(mctl), .modem_n(modem_n), .irq(irq), .id_val(id_val),
        .en_view(en_view), .msr_val(msr_val)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; int_en = 4'h0; fifo_en = 1'b0; trig_sel = 2'b00;
        rx_level = '0; rx_timeout = 1'b0; line_err = 1'b0; thr_empty = 1'b1;
        thr_write = 1'b0; id_read = 1'b0; msr_read = 1'b0; loopback = 1'b0;
        mctl = 4'h0; modem_n = 4'hF;
        tick(); tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic t_reset_state();
        do_reset();
        settle();
        chk("R7 reset id", id_val, 8'h01);
        chk("R11 reset irq", {7'b0, irq}, 8'h00);
        chk("R8 reset msr", msr_val, 8'h00);
        chk("R1 reset en_view", en_view, 8'h00);
        fifo_en = 1'b1; settle();
        chk("R7 fifo bits", id_val, 8'hC1);
    endtask

    task automatic t_enable_view();
        do_reset();
        int_en = 4'b1010; settle();
        chk("R1 en_view 1010", en_view, 8'h0A);
        int_en = 4'b0101; settle();
        chk("R1 en_view 0101", en_view, 8'h05);
    endtask

    task automatic t_tx_empty();
        do_reset();
        mctl = 4'b1000; int_en = 4'b0010;
        tick();
        chk("R5 enable rise while empty", id_val, 8'h02);
        chk("R11 irq on tx", {7'b0, irq}, 8'h01);
        id_read = 1'b1; tick(); id_read = 1'b0; settle();
        chk("R5 cleared by id read", id_val, 8'h01);
        thr_empty = 1'b0; tick();
        chk("R5 no event while full", id_val, 8'h01);
        thr_empty = 1'b1; tick();
        chk("R5 empty rise", id_val, 8'h02);
        thr_write = 1'b1; tick(); thr_write = 1'b0; settle();
        chk("R5 cleared by write", id_val, 8'h01);
    endtask

    task automatic t_rx_levels();
        do_reset();
        int_en = 4'b0001;
        rx_level = 5'd0; settle();
        chk("R3 empty no fifo", id_val, 8'h01);
        rx_level = 5'd1; settle();
        chk("R3 one word no fifo", id_val, 8'h04);
        fifo_en = 1'b1; trig_sel = 2'b00; settle();
        chk("R3 trig 1", id_val, 8'hC4);
        trig_sel = 2'b01; rx_level = 5'd3; settle();
        chk("R3 trig 4 below", id_val, 8'hC1);
        rx_level = 5'd4; settle();
        chk("R3 trig 4 at", id_val, 8'hC4);
        trig_sel = 2'b10; rx_level = 5'd7; settle();
        chk("R3 trig 8 below", id_val, 8'hC1);
        rx_level = 5'd8; settle();
        chk("R3 trig 8 at", id_val, 8'hC4);
        trig_sel = 2'b11; rx_level = 5'd13; settle();
        chk("R3 trig 14 below", id_val, 8'hC1);
        rx_level = 5'd14; settle();
        chk("R3 trig 14 at", id_val, 8'hC4);
        rx_timeout = 1'b1; settle();
        chk("R3 level over timeout", id_val, 8'hC4);
        rx_level = 5'd2; settle();
        chk("R4 timeout code", id_val, 8'hCC);
    endtask

    task automatic t_priority();
        do_reset();
        mctl = 4'b1000; int_en = 4'hF; modem_n = 4'b1110;
        tick();
        line_err = 1'b1; rx_level = 5'd1; settle();
        chk("R2 line over all", id_val, 8'h06);
        line_err = 1'b0; settle();
        chk("R3 rx over tx", id_val, 8'h04);
        rx_level = 5'd0; rx_timeout = 1'b1; settle();
        chk("R4 timeout over tx", id_val, 8'h0C);
        rx_timeout = 1'b0; settle();
        chk("R5 tx over modem", id_val, 8'h02);
        id_read = 1'b1; tick(); id_read = 1'b0; settle();
        chk("R6 modem lowest", id_val, 8'h00);
        chk("R11 irq modem", {7'b0, irq}, 8'h01);
        mctl = 4'b0000; settle();
        chk("R11 gate off", {7'b0, irq}, 8'h00);
        chk("R11 id unchanged when gated", id_val, 8'h00);
        int_en = 4'b0111; settle();
        chk("R6 disabled modem", id_val, 8'h01);
    endtask

    task automatic t_modem();
        do_reset();
        modem_n = 4'b1110; tick();
        chk("R8 cts change", msr_val, 8'h11);
        msr_read = 1'b1; tick(); msr_read = 1'b0; settle();
        chk("R9 read clears", msr_val, 8'h10);
        modem_n = 4'b1010; tick();
        chk("R8 ring assert no flag", msr_val, 8'h50);
        modem_n = 4'b1110; tick();
        chk("R8 ring trailing flag", msr_val, 8'h14);
        msr_read = 1'b1; tick(); msr_read = 1'b0; settle();
        chk("R9 ring flag cleared", msr_val, 8'h10);
        msr_read = 1'b1; modem_n = 4'b1100; tick(); msr_read = 1'b0; settle();
        chk("R9 change during read", msr_val, 8'h32);
        modem_n = 4'b0100; tick();
        chk("R8 dcd change", msr_val, 8'hBA);
    endtask

    task automatic t_loopback();
        do_reset();
        loopback = 1'b1; mctl = 4'b0000; tick();
        chk("R10 loop quiet", msr_val, 8'h00);
        mctl = 4'b0101; tick();
        chk("R10 rts and out1 routed", msr_val, 8'h51);
        modem_n = 4'b0000; tick();
        chk("R10 pins ignored", msr_val, 8'h51);
        mctl = 4'b0001; tick();
        chk("R10 out1 trailing ring", msr_val, 8'h15);
        mctl = 4'b1011; tick();
        chk("R10 dtr and out2 routed", msr_val, 8'hBF);
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset_state();
        t_enable_view();
        t_tx_empty();
        t_rx_levels();
        t_priority();
        t_modem();
        t_loopback();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule